// File: doc/BRIEF.md
# Serial-to-Parallel Word Framer with Comma Lock

This block sits behind a clock-and-data recovery stage and runs on the recovered bit clock. Each cycle it takes one serial bit and builds a 20-bit parallel word from the bits. Bit 0 of each word is the oldest bit in it. A word clock and its inverse mark each new word. When comma search is on, the block watches the bit stream for the 7-bit comma sequence. It then moves the word boundary so the comma fills the lowest seven bits of a word. When search is off, the existing boundary is kept.

The receive bit can come from the external line or from the local transmit stream, which gives a near-end loopback. The transmit line output idles high while loopback is on or while transmission is disabled. A status flag marks a word that is entirely zeros or entirely ones, which is taken as an open link, but only when the external line is the source. A second flag marks a comma-framed word during the low half of the word clock.

Top module: `deser_comma_align`

## Requirements
- R1: `rx_word` holds 20 consecutive received bits, with `rx_word[0]` the earliest and `rx_word[19]` the latest.
- R2: `word_clk` rises in the same bit-clock cycle that a new word appears on `rx_word`, and `rx_word` changes at no other time. When no realignment occurs, words are 20 bit clocks apart and `word_clk` stays high for the first 10 of them. `word_clk_n` is always the inverse of `word_clk`.
- R3: The comma is the time sequence 0,0,1,1,1,1,1, which is `rx_word[6:0] == 7'b1111100` once framed. While `align_en` is high, the bit that completes a comma is followed by exactly 13 more bits before the word ends, so that word carries the comma in bits 0 to 6. A comma that is already framed leaves the boundary unchanged.
- R4: While `align_en` is low, the word boundary does not move: a comma arriving at any offset leaves words exactly 20 bits apart.
- R5: `comma_flag` is high only while `word_clk` is low and the current word has `rx_word[6:0] == 7'b1111100`, and only if `align_en` was high at the preceding bit clock. It is low whenever `align_en` is low.
- R6: With `lpbk_en` low, `link_dead` is high exactly when the current word is all zeros or all ones. With `lpbk_en` high, it is low.
- R7: With `lpbk_en` high, the framer takes its bits from `tx_ser` and ignores `ser_in`.
- R8: `line_out` is a registered copy of `tx_ser` when `lpbk_en` and `tx_en_n` are both low. Otherwise it is held high.
- R9: A synchronous high `rst` clears the word and the bit phase. It drives `word_clk` low, `word_clk_n` high, `comma_flag` low, `link_dead` low and `line_out` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial bit from the external line |
| tx_ser | input | 1 | Local transmit serial bit, also the loopback source |
| lpbk_en | input | 1 | Selects the internal loopback as the receive source |
| tx_en_n | input | 1 | Transmit enable, active low |
| align_en | input | 1 | Enables comma search and boundary moves |
| rx_word | output | 20 | Assembled parallel word, bit 0 earliest |
| word_clk | output | 1 | Word clock, rising with each new word |
| word_clk_n | output | 1 | Inverse of the word clock |
| comma_flag | output | 1 | Current word holds a framed comma (low half of word clock) |
| link_dead | output | 1 | Current word is constant while the external line is in use |
| line_out | output | 1 | Transmit line output, high when idle |

## Verification
The in-line assertions check, on every cycle, the rules that relate a few signals over a short window:
- the word changes only on a word-clock rise, and the two word clocks stay inverse;
- the comma flag never appears in the high half of the word clock, and it drops when search is disabled;
- the dead-link flag stays quiet under loopback;
- the transmit line either idles or follows its input;
- a 20-bit period is kept while search is held off.

The bench scenarios are needed for the rest. They send a known word sequence at odd bit offsets and check that the boundary locks onto the first comma. They check that the boundary holds when search is switched off, and that it locks again once search returns. They also show that loopback data frames correctly, and that constant line input is flagged only when the external source is selected.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    // Default geometry of the framer
    localparam int DEF_WORD_W = 20;
    localparam int DEF_MARK_W = 7;
    // Comma as framed in word bits [6:0]: bit 0 arrives first (0,0,1,1,1,1,1)
    localparam logic [DEF_MARK_W-1:0] DEF_MARK_PAT = 7'b1111100;

    // Source of the bit entering the shift register
    typedef enum logic {
        SRC_LINE = 1'b0,
        SRC_WRAP = 1'b1
    } rx_src_e;

    // Per-bit framing events handed from the framer to the word stage
    typedef struct packed {
        logic emit;      // this bit completes a word
        logic hit;       // this bit completes a comma (search enabled)
        logic wclk_nxt;  // word clock level after this edge
    } frame_ev_t;

    function automatic rx_src_e pick_src(input logic wrap);
        return wrap ? SRC_WRAP : SRC_LINE;
    endfunction

endpackage

// File: rtl/dsa_shifter.sv
module dsa_shifter
    import dsa_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              tx_ser,
    input  logic              lpbk_en,
    output logic [WORD_W-1:0] sreg_nxt
);

    logic [WORD_W-1:0] sreg_q;
    rx_src_e           src;
    logic              bit_in;

    always_comb begin
        src = pick_src(lpbk_en);
        unique case (src)
            SRC_WRAP: bit_in = tx_ser;
            default:  bit_in = ser_in;
        endcase
        // newest bit enters at the top; oldest drifts toward bit 0
        sreg_nxt = {bit_in, sreg_q[WORD_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) sreg_q <= '0;
        else     sreg_q <= sreg_nxt;
    end

endmodule

// File: rtl/dsa_framer.sv
module dsa_framer
    import dsa_pkg::*;
#(
    parameter int                  WORD_W   = DEF_WORD_W,
    parameter int                  MARK_W   = DEF_MARK_W,
    parameter logic [MARK_W-1:0]   MARK_PAT = DEF_MARK_PAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              align_en,
    input  logic [WORD_W-1:0] sreg_nxt,
    output frame_ev_t         ev,
    output logic              word_clk,
    output logic              word_clk_n
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam int PH_W  = CNT_W + 1;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(WORD_W - 1);
    // after a comma completes, WORD_W-MARK_W more bits close the word
    localparam logic [CNT_W-1:0] RESYNC = CNT_W'(MARK_W);
    localparam logic [PH_W-1:0]  HALF   = PH_W'(WORD_W / 2);
    localparam logic [PH_W-1:0]  PH_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic             wclk_q, wclk_n_q;

    always_comb begin
        ev.emit = (cnt_q == LAST);
        ev.hit  = align_en && (sreg_nxt[WORD_W-1 -: MARK_W] == MARK_PAT);
        if (ev.hit)       cnt_d = RESYNC;
        else if (ev.emit) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
        if (ev.emit)               ph_d = '0;
        else if (ph_q == PH_MAX)   ph_d = ph_q;
        else                       ph_d = ph_q + 1'b1;
        ev.wclk_nxt = (ph_d < HALF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            ph_q     <= PH_MAX;
            wclk_q   <= 1'b0;
            wclk_n_q <= 1'b1;
        end else begin
            cnt_q    <= cnt_d;
            ph_q     <= ph_d;
            wclk_q   <= ev.wclk_nxt;
            wclk_n_q <= ~ev.wclk_nxt;
        end
    end

    assign word_clk   = wclk_q;
    assign word_clk_n = wclk_n_q;

    // Checker: bits since the last word, and whether search stayed off
    logic [PH_W-1:0] gap_q;
    logic            held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            held_q <= 1'b1;
        end else begin
            gap_q  <= ev.emit ? '0 : ((gap_q == PH_MAX) ? gap_q : gap_q + 1'b1);
            held_q <= ev.emit ? ~align_en : (held_q & ~align_en);
        end
    end

    // R4: with search off since the previous word, the period is fixed
    p_fixed_period_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.emit && held_q) |-> (gap_q == PH_W'(WORD_W - 1)));

endmodule

// File: rtl/dsa_word_out.sv
module dsa_word_out
    import dsa_pkg::*;
#(
    parameter int                  WORD_W   = DEF_WORD_W,
    parameter int                  MARK_W   = DEF_MARK_W,
    parameter logic [MARK_W-1:0]   MARK_PAT = DEF_MARK_PAT
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_ev_t         ev,
    input  logic              align_en,
    input  logic              lpbk_en,
    input  logic [WORD_W-1:0] sreg_nxt,
    output logic [WORD_W-1:0] rx_word,
    output logic              comma_flag,
    output logic              link_dead
);

    logic [WORD_W-1:0] word_q, word_d;
    logic              comma_q, dead_q;
    logic              framed, uniform;

    always_comb begin
        word_d  = ev.emit ? sreg_nxt : word_q;
        framed  = (word_d[MARK_W-1:0] == MARK_PAT);
        uniform = (&word_d) | ~(|word_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            comma_q <= 1'b0;
            dead_q  <= 1'b0;
        end else begin
            word_q  <= word_d;
            comma_q <= align_en & framed & ~ev.wclk_nxt;
            dead_q  <= ~lpbk_en & uniform;
        end
    end

    assign rx_word    = word_q;
    assign comma_flag = comma_q;
    assign link_dead  = dead_q;

    // R5: flag drops once search is disabled
    p_flag_off_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!align_en)) |-> !comma_q);

    // R6: loopback silences the open-link flag
    p_dead_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(lpbk_en)) |-> !dead_q);

endmodule

// File: rtl/dsa_tx_line.sv
module dsa_tx_line (
    input  logic clk,
    input  logic rst,
    input  logic tx_ser,
    input  logic tx_en_n,
    input  logic lpbk_en,
    output logic line_out
);

    logic line_q;

    always_ff @(posedge clk) begin
        if (rst)                     line_q <= 1'b1;
        else if (lpbk_en || tx_en_n) line_q <= 1'b1;
        else                         line_q <= tx_ser;
    end

    assign line_out = line_q;

    // R8: idle level whenever loopback or disable was requested
    p_line_idle_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(lpbk_en || tx_en_n)) |-> line_q);

    // R8: otherwise the line carries the previous transmit bit
    p_line_data_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!lpbk_en && !tx_en_n)) |-> (line_q == $past(tx_ser)));

endmodule

// File: rtl/deser_comma_align.sv
module deser_comma_align
    import dsa_pkg::*;
#(
    parameter int                  WORD_W   = DEF_WORD_W,
    parameter int                  MARK_W   = DEF_MARK_W,
    parameter logic [MARK_W-1:0]   MARK_PAT = DEF_MARK_PAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              tx_ser,
    input  logic              lpbk_en,
    input  logic              tx_en_n,
    input  logic              align_en,
    output logic [WORD_W-1:0] rx_word,
    output logic              word_clk,
    output logic              word_clk_n,
    output logic              comma_flag,
    output logic              link_dead,
    output logic              line_out
);

    logic [WORD_W-1:0] sreg_nxt;
    frame_ev_t         ev;

    dsa_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .tx_ser   (tx_ser),
        .lpbk_en  (lpbk_en),
        .sreg_nxt (sreg_nxt)
    );

    dsa_framer #(.WORD_W(WORD_W), .MARK_W(MARK_W), .MARK_PAT(MARK_PAT)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .align_en   (align_en),
        .sreg_nxt   (sreg_nxt),
        .ev         (ev),
        .word_clk   (word_clk),
        .word_clk_n (word_clk_n)
    );

    dsa_word_out #(.WORD_W(WORD_W), .MARK_W(MARK_W), .MARK_PAT(MARK_PAT)) u_word (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .align_en   (align_en),
        .lpbk_en    (lpbk_en),
        .sreg_nxt   (sreg_nxt),
        .rx_word    (rx_word),
        .comma_flag (comma_flag),
        .link_dead  (link_dead)
    );

    dsa_tx_line u_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_ser   (tx_ser),
        .tx_en_n  (tx_en_n),
        .lpbk_en  (lpbk_en),
        .line_out (line_out)
    );

    // R2: the word only moves together with a word-clock rise
    p_word_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        !$rose(word_clk) |-> $stable(rx_word));

    // R2: the two word clocks stay inverse
    p_clk_inverse_r2: assert property (@(posedge clk) disable iff (rst)
        word_clk_n == !word_clk);

    // R5: comma flag only in the low half of the word clock
    p_flag_low_half_r5: assert property (@(posedge clk) disable iff (rst)
        comma_flag |-> !word_clk);

endmodule

// File: tb/test_deser_comma_align.sv
`timescale 1ns/1ps
module test_deser_comma_align;

    localparam int W  = 20;
    localparam int NV = 8;
    localparam logic [W-1:0] MARK_WORD = 20'h5557C;
    // Stimulus words; once locked, the output must repeat them from the comma on
    localparam logic [W-1:0] VEC [NV] = '{
        20'hA5A5A, 20'h5A5A5, 20'h5557C, 20'h9A5A6,
        20'h6A965, 20'h33CC3, 20'h5557C, 20'hA5A5A
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b1, tx_ser = 1'b1, lpbk_en = 1'b0, tx_en_n = 1'b1, align_en = 1'b1;
    logic [W-1:0] rx_word;
    logic word_clk, word_clk_n, comma_flag, link_dead, line_out;

    int checks = 0, fails = 0;
    int bit_ctr = 0, last_rise = 0, ncap = 0;
    logic prev_wclk = 1'b0;
    logic use_tx = 1'b0;
    logic [W-1:0] cap_word [64];
    int cap_gap [64];

    always #2 clk = ~clk;

    deser_comma_align i_deser_comma_align (
        .clk(clk), .rst(rst), .ser_in(ser_in), .tx_ser(tx_ser), .lpbk_en(lpbk_en),
        .tx_en_n(tx_en_n), .align_en(align_en), .rx_word(rx_word), .word_clk(word_clk),
        .word_clk_n(word_clk_n), .comma_flag(comma_flag), .link_dead(link_dead),
        .line_out(line_out)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        logic exp_flag;
        if (use_tx) begin tx_ser = b; ser_in = 1'b0; end
        else        begin ser_in = b; tx_ser = 1'b1; end
        @(posedge clk);
        @(negedge clk);
        bit_ctr++;
        exp_flag = align_en && (rx_word[6:0] == 7'b1111100) && !word_clk;
        check(comma_flag == exp_flag, "R5 comma_flag", {19'd0, comma_flag}, {19'd0, exp_flag});
        check(word_clk_n == !word_clk, "R2 word_clk_n", {19'd0, word_clk_n}, {19'd0, !word_clk});
        if (word_clk && !prev_wclk) begin
            if (ncap < 64) begin
                cap_word[ncap] = rx_word;
                cap_gap[ncap]  = bit_ctr - last_rise;
                ncap++;
            end
            last_rise = bit_ctr;
        end
        prev_wclk = word_clk;
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int k = 0; k < W; k++) send_bit(w[k]);
    endtask

    task automatic send_fill(input int n);
        for (int k = 0; k < n; k++) send_bit(k[0] ? 1'b0 : 1'b1);
    endtask

    task automatic run_table();
        for (int i = 0; i < NV; i++) send_word(VEC[i]);
        send_fill(25);
    endtask

    // After the first framed comma, each captured word matches the table
    task automatic verify_lock(input string req);
        int j;
        j = -1;
        for (int c = 0; c < ncap; c++)
            if (j < 0 && cap_word[c] == MARK_WORD) j = c;
        check(j >= 0, req, 20'd0, MARK_WORD);
        if (j >= 0 && j + 5 < 64) begin
            for (int k = 1; k <= 5; k++) begin
                check(cap_word[j+k] == VEC[2+k], req, cap_word[j+k], VEC[2+k]);
                check(cap_gap[j+k] == W, "R2 word period", W'(cap_gap[j+k]), W'(W));
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rx_word == '0, "R9 rx_word", rx_word, '0);
        check(!word_clk && word_clk_n, "R9 word clocks", {18'd0, word_clk, word_clk_n}, 20'd1);
        check(!comma_flag, "R9 comma_flag", {19'd0, comma_flag}, 20'd0);
        check(!link_dead, "R9 link_dead", {19'd0, link_dead}, 20'd0);
        check(line_out, "R9 line_out", {19'd0, line_out}, 20'd1);
        rst = 1'b0;

        // R1 R3: lock at offset 7 from the external line
        ncap = 0;
        send_fill(7);
        run_table();
        verify_lock("R1 R3 lock");
        check(!link_dead, "R6 live data", {19'd0, link_dead}, 20'd0);

        // R4: search off, stream shifted by 3 bits, boundary must not move
        align_en = 1'b0;
        ncap = 0;
        send_fill(3);
        run_table();
        for (int c = 1; c < ncap; c++) begin
            check(cap_word[c] != MARK_WORD, "R4 no realign", cap_word[c], MARK_WORD);
            check(cap_gap[c] == W, "R4 period held", W'(cap_gap[c]), W'(W));
        end

        // R3: search back on, boundary follows the comma again
        align_en = 1'b1;
        ncap = 0;
        run_table();
        verify_lock("R3 relock");

        // R7: loopback source at offset 13, line input held at zero
        lpbk_en = 1'b1;
        tx_en_n = 1'b0;
        use_tx  = 1'b1;
        ncap = 0;
        send_fill(13);
        run_table();
        verify_lock("R7 loopback lock");
        check(line_out, "R8 idle under loopback", {19'd0, line_out}, 20'd1);
        check(!link_dead, "R6 loopback quiet", {19'd0, link_dead}, 20'd0);

        // R6: constant external line flags an open link
        lpbk_en = 1'b0;
        use_tx  = 1'b0;
        for (int k = 0; k < 45; k++) send_bit(1'b0);
        check(rx_word == '0, "R6 zero word", rx_word, '0);
        check(link_dead, "R6 zeros", {19'd0, link_dead}, 20'd1);
        for (int k = 0; k < 45; k++) send_bit(1'b1);
        check(rx_word == '1, "R6 ones word", rx_word, '1);
        check(link_dead, "R6 ones", {19'd0, link_dead}, 20'd1);
        lpbk_en = 1'b1;
        use_tx  = 1'b1;
        send_bit(1'b1);
        check(!link_dead, "R6 loopback masks", {19'd0, link_dead}, 20'd0);
        for (int k = 0; k < 45; k++) send_bit(1'b1);
        check(!link_dead, "R6 loopback constant", {19'd0, link_dead}, 20'd0);

        // R8: transmit line follows tx_ser only when enabled and not looped
        lpbk_en = 1'b0;
        tx_en_n = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tx_ser = k[0] ^ k[2];
            @(posedge clk);
            @(negedge clk);
            check(line_out == tx_ser, "R8 line data", {19'd0, line_out}, {19'd0, tx_ser});
        end
        tx_en_n = 1'b1;
        tx_ser  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(line_out, "R8 disabled idle", {19'd0, line_out}, 20'd1);

        // R9: reset in the middle of traffic
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(rx_word == '0, "R9 mid reset word", rx_word, '0);
        check(!word_clk && !comma_flag && !link_dead && line_out, "R9 mid reset flags",
              {16'd0, word_clk, comma_flag, link_dead, line_out}, 20'd1);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule